// File: doc/BRIEF.md
# Latchable Fault Status Register

This block reports a small group of external fault lines to a processor through a simple register port. Each line is first brought into the clock domain by a synchroniser. A per-line polarity bit then decides whether the line is active high or active low. The status bits always show this adjusted level, never the raw pin.

One mode bit sets how the status bits behave. In live mode each status bit is read-only and follows the adjusted level of its line. In latched mode each status bit is a sticky flag. The flag records that its line went to the active state at least once, and software clears it by writing a one to its position. Software normally reads the status, handles the fault, and then writes back the bits it has handled. A fault that arrives during that write still stays flagged.

Top module: `fault_status_reg`

## Requirements
- R1: After reset, the mode bit, every polarity bit and every status bit read as 0.
- R2: In live mode (mode bit 0), status bit i reads as the adjusted level of fault line i. The read data changes in the second clock edge after the pin changes.
- R3: Polarity bit i at 0 makes line i active high (adjusted level = pin). Polarity bit i at 1 makes it active low (adjusted level = inverted pin).
- R4: In latched mode (mode bit 1), status bit i sets when the adjusted level of line i rises from 0 to 1. It reads as 1 from the third clock edge after the pin change. It then stays 1 when the line returns to inactive.
- R5: In latched mode, writing the status register clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R6: When a rising transition and a write-1 clear reach the same flag in the same clock cycle, the flag ends up set.
- R7: In live mode, writes to the status register have no effect.
- R8: Entering latched mode starts every flag at 0. A line that is already active when the mode switches does not set its flag. Only later rising transitions do.
- R9: Fault line i maps to status bit i for i = 0, 1, 2. Status bits above the implemented lines read 0, and the unused address 3 reads 0.
- R10: Register addresses: 0 = control (bit 0 = mode), 1 = polarity (one bit per line, bit i for line i), 2 = status. Writes to control and polarity read back only their implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | NUM_FAULTS | Raw fault lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for addr_i (combinational) |

## Verification
Live mode is swept over every pairing of polarity setting and pin pattern. This tells a correct per-bit inversion apart from a swapped bit, a lost bit or a global inversion.

Latched mode is swept over every adjusted pattern under every polarity setting. After the set, the lines are released to show the flags hold. Then writes with all-zero data and with single-bit data show that clearing is per bit.

Directed sequences cover the rest. One places a rising transition in the exact cycle of a clear write, which separates set-wins from clear-wins. Another switches mode while a line is held active, which separates edge capture from level capture. A third writes in live mode to confirm the write is ignored.

// File: rtl/fault_status_pkg.sv
package fault_status_pkg;
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_SENSE  = 1;
  localparam int unsigned ADDR_STATUS = 2;
  localparam int unsigned CTRL_MODE_BIT = 0;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fault_cfg_regs.sv
module fault_cfg_regs
  import fault_status_pkg::*;
#(
  parameter int unsigned NUM_FAULTS = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic                  latch_o,
  output logic [NUM_FAULTS-1:0] sense_o,
  output logic [NUM_FAULTS-1:0] clr_o
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(ADDR_SENSE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);

  logic                  latch_q;
  logic [NUM_FAULTS-1:0] sense_q;
  logic                  wr_ctrl, wr_sense, wr_status;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_sense  = wr_en_i && (addr_i == A_SENSE);
  assign wr_status = wr_en_i && (addr_i == A_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      sense_q <= '0;
    end else begin
      if (wr_ctrl)  latch_q <= wr_data_i[CTRL_MODE_BIT];
      if (wr_sense) sense_q <= wr_data_i[NUM_FAULTS-1:0];
    end
  end

  // write-one-to-clear only acts in latched mode
  assign clr_o   = (wr_status && latch_q) ? wr_data_i[NUM_FAULTS-1:0] : '0;
  assign latch_o = latch_q;
  assign sense_o = sense_q;

  logic unused_wdata;
  assign unused_wdata = ^wr_data_i;
endmodule

// File: rtl/fault_flag_cell.sv
module fault_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic sense_i,
  input  logic latch_i,
  input  logic clr_i,
  output logic adj_o,
  output logic rise_o,
  output logic flag_o
);
  logic prev_q, flag_q;

  assign adj_o  = lvl_i ^ sense_i;
  assign rise_o = adj_o & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= adj_o;
      if (!latch_i)    flag_q <= 1'b0;
      else if (rise_o) flag_q <= 1'b1;  // set beats clear
      else if (clr_i)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fault_status_pkg::*;
#(
  parameter int unsigned NUM_FAULTS  = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FAULTS-1:0] fault_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DATA_W-1:0]     rd_data_o
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(ADDR_SENSE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);

  logic [NUM_FAULTS-1:0] sync_vec, sense_vec, clr_vec;
  logic [NUM_FAULTS-1:0] adj_vec, rise_vec, flag_vec, stat_vec;
  logic                  latch_q;

  fault_sync #(.WIDTH(NUM_FAULTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fault_i),
    .q_o   (sync_vec)
  );

  fault_cfg_regs #(.NUM_FAULTS(NUM_FAULTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .latch_o  (latch_q),
    .sense_o  (sense_vec),
    .clr_o    (clr_vec)
  );

  for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_cell
    fault_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (sync_vec[i]),
      .sense_i(sense_vec[i]),
      .latch_i(latch_q),
      .clr_i  (clr_vec[i]),
      .adj_o  (adj_vec[i]),
      .rise_o (rise_vec[i]),
      .flag_o (flag_vec[i])
    );
  end

  assign stat_vec = latch_q ? flag_vec : adj_vec;

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_CTRL:   rd_data_o[CTRL_MODE_BIT]  = latch_q;
      A_SENSE:  rd_data_o[NUM_FAULTS-1:0] = sense_vec;
      A_STATUS: rd_data_o[NUM_FAULTS-1:0] = stat_vec;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/fault_status_chk.sv
module fault_status_chk
  import fault_status_pkg::*;
#(
  parameter int unsigned NUM_FAULTS = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  latch_i,
  input logic [NUM_FAULTS-1:0] flag_i,
  input logic [NUM_FAULTS-1:0] rise_i,
  input logic [NUM_FAULTS-1:0] clr_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     rd_data_i
);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && clr_i == '0) |=> (!latch_i || ((flag_i & $past(flag_i)) == $past(flag_i))));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && (clr_i & ~rise_i) != '0) |=> ((flag_i & $past(clr_i & ~rise_i)) == '0));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && rise_i != '0) |=> (!latch_i || ((flag_i & $past(rise_i)) == $past(rise_i))));

  p_live_no_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |-> (clr_i == '0));

  p_live_flags_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> (flag_i == '0));

  p_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADDR_STATUS)) |-> (rd_data_i[DATA_W-1:NUM_FAULTS] == '0));
endmodule

bind fault_status_reg fault_status_chk #(
  .NUM_FAULTS(NUM_FAULTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .latch_i  (latch_q),
  .flag_i   (flag_vec),
  .rise_i   (rise_vec),
  .clr_i    (clr_vec),
  .addr_i   (addr_i),
  .rd_data_i(rd_data_o)
);

// File: tb/fault_status_reg_tb.sv
module fault_status_reg_tb;
  localparam int N  = 3;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [AW-1:0] A_CTRL = 0, A_SENSE = 1, A_STAT = 2, A_NONE = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]  fault_i = '0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [DW-1:0] d;
  int checks = 0, errors = 0;

  always #4 clk_i = ~clk_i;

  fault_status_reg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = v;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    addr_i = a; #1; v = rd_data_o;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick(3);
    // R1 reset state
    rd(A_CTRL, d);  check("R1 ctrl", d, 0);
    rd(A_SENSE, d); check("R1 sense", d, 0);
    rd(A_STAT, d);  check("R1 status", d, 0);

    // R10 readback of implemented bits only
    wr(A_SENSE, 32'hFFFF_FFF8); rd(A_SENSE, d); check("R10 sense mask", d, 0);
    wr(A_SENSE, 32'hFFFF_FFFF); rd(A_SENSE, d); check("R10 sense all", d, 7);
    wr(A_CTRL, 32'hFFFF_FFFE);  rd(A_CTRL, d);  check("R10 ctrl mask", d, 0);

    // R2 R3 live sweep: status = pin ^ sense
    for (int s = 0; s < 8; s++) begin
      wr(A_SENSE, DW'(s));
      for (int p = 0; p < 8; p++) begin
        fault_i = N'(p);
        tick(2);
        rd(A_STAT, d);
        check("R2 R3 live", d, DW'(p ^ s));
      end
    end

    // R4 R5 latched sweep
    wr(A_CTRL, 1);
    for (int s = 0; s < 8; s++) begin
      wr(A_SENSE, DW'(s));
      for (int p = 0; p < 8; p++) begin
        fault_i = N'(s);            // adjusted all inactive
        tick(3);
        wr(A_STAT, 7);
        rd(A_STAT, d); check("R5 clear all", d, 0);
        fault_i = N'(s ^ p);
        tick(3);
        rd(A_STAT, d); check("R4 set", d, DW'(p));
        fault_i = N'(s);
        tick(3);
        rd(A_STAT, d); check("R4 hold", d, DW'(p));
        wr(A_STAT, 0);
        rd(A_STAT, d); check("R5 write zero", d, DW'(p));
        for (int k = 0; k < N; k++) begin
          wr(A_STAT, DW'(1 << k));
          rd(A_STAT, d);
          check("R5 R9 per bit clear", d, DW'(p & ~((1 << (k + 1)) - 1)));
        end
      end
    end

    // R6 set wins over simultaneous clear
    wr(A_SENSE, 0);
    fault_i = '0; tick(3);
    wr(A_STAT, 7);
    fault_i = 3'b010;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    wr(A_STAT, 32'h2);
    rd(A_STAT, d); check("R6 set wins", d, 32'h2);
    tick(2);
    rd(A_STAT, d); check("R6 kept", d, 32'h2);

    // R7 live writes ignored, R8 mode entry
    wr(A_CTRL, 0);
    fault_i = 3'b101; tick(3);
    rd(A_STAT, d); check("R2 live", d, 5);
    wr(A_STAT, 7);
    rd(A_STAT, d); check("R7 live write", d, 5);
    wr(A_CTRL, 1);
    tick(2);
    rd(A_STAT, d); check("R8 held active no set", d, 0);
    fault_i = 3'b000; tick(3);
    fault_i = 3'b001; tick(3);
    rd(A_STAT, d); check("R8 later edge", d, 1);
    rd(A_CTRL, d); check("R10 ctrl", d, 1);

    // R9 unused address
    fault_i = 3'b111; tick(3);
    rd(A_NONE, d); check("R9 unused addr", d, 0);
    rd(A_STAT, d); check("R9 all bits", d, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule